// File: doc/BRIEF.md
# Eight-Bit Compare Timer

This block is an 8-bit up-counter with a single compare channel, meant to sit behind a small register port in a larger chip. It advances by one on every cycle in which the one-cycle `tick_en` strobe is high. In the free-running mode it wraps from 0xFF to 0x00. In the wrap-on-compare mode it returns to zero on the tick that finds it equal to the compare register, so the compare value sets the period.

A compare match sets a sticky compare flag and drives the waveform pin through a 2-bit action field. That field only shapes the pin and never changes how the counter steps. The counter passing from 0xFF to 0x00 sets a sticky overflow flag. Each flag drives its own interrupt request line and is cleared by an acknowledge pulse or by a write-one to the flag register.

Top module: `cmp_timer8`

## Requirements
- R1: On reset the counter, compare register, control register, both flags and the waveform pin all read 0.
- R2: The register port uses address 0 for the counter, 1 for the compare value, 2 for control (bits [1:0] mode, bits [3:2] pin action, upper bits read 0) and 3 for flags (bit 0 overflow, bit 1 compare). `rd_data` shows the register selected by `rd_addr` combinationally, and each write takes effect at the next clock edge.
- R3: Mode values 0, 1 and 3 select free-running counting. A tick adds one, the counter wraps from 0xFF to 0x00, and a compare match never clears it. Without a tick the counter holds.
- R4: A tick that moves the counter from 0xFF to 0x00, in any mode, sets the overflow flag at the same clock edge at which the counter becomes 0. Hardware never clears the flag.
- R5: Mode value 2 selects wrap-on-compare. A tick taken while the counter equals the compare register loads 0 into the counter.
- R6: A compare match is a tick, with no counter write in the same cycle, while the counter equals the compare register. A match sets the compare flag at the next edge.
- R7: The pin action field is encoded as 0 = pin driven 0 with its held state untouched by matches, 1 = toggle, 2 = clear and 3 = set. The action is applied to the held pin state at the edge of the match. A nonzero action shows the held state on `wave_out`.
- R8: The pin action field has no effect on the counter sequence.
- R9: A counter write in the same cycle as a tick wins: the written value is loaded, and no match and no overflow occur in that cycle.
- R10: An acknowledge pulse, or a write to address 3 with a 1 in a flag's bit, clears that flag. A 0 bit leaves the flag alone, and a hardware set in the same cycle wins over a clear.
- R11: `ovf_irq` and `cmp_irq` follow the overflow and compare flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| ovf_ack | input | 1 | Overflow interrupt acknowledge |
| cmp_ack | input | 1 | Compare interrupt acknowledge |
| wave_out | output | 1 | Compare waveform pin |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
A wrong counter value becomes visible on the first read of address 0 after the bad edge. It also shifts every later match and wrap, so it shows within one period on the flags and on the pin. A wrong flag or pin state appears on the very next cycle, because both drive outputs directly. The bench compares every output and a rotating register read against a behavioural model on every clock. A divergence is therefore caught within four cycles at most.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'd0,
        MODE_RSV1    = 2'd1,
        MODE_WRAPCMP = 2'd2,
        MODE_RSV3    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        REG_COUNT   = 2'd0,
        REG_COMPARE = 2'd1,
        REG_CONTROL = 2'd2,
        REG_FLAGS   = 2'd3
    } reg_e;

    // control register layout: action in [3:2], mode in [1:0]
    typedef struct packed {
        act_e  act;
        mode_e mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int NFLAG  = 2;
    localparam int FLAG_OVF = 0;
    localparam int FLAG_CMP = 1;

    function automatic logic wraps_on_compare(mode_e m);
        return m == MODE_WRAPCMP;
    endfunction

    function automatic logic pin_after_match(act_e a, logic cur);
        case (a)
            ACT_TOGGLE: return ~cur;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cmp_val,
    input  logic         wrap_on_cmp,
    output logic [W-1:0] cnt_q,
    output logic         hit,
    output logic         wrapped
);
    localparam logic [W-1:0] TOP_VAL = '1;

    logic         step;
    logic [W-1:0] cnt_d;

    assign step    = tick && !cnt_wr;
    assign hit     = step && (cnt_q == cmp_val);
    assign wrapped = step && (cnt_q == TOP_VAL);

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr)
            cnt_d = wr_data;
        else if (step) begin
            if (wrap_on_cmp && hit)
                cnt_d = '0;
            else
                cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assert_free_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && !wrap_on_cmp) |=> cnt_q == W'($past(cnt_q) + 1'b1));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt_q));

    assert_cmp_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && wrap_on_cmp && cnt_q == cmp_val) |=> cnt_q == '0);

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt_q == $past(wr_data));

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags
    import tmr8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] hw_set,
    input  logic [NFLAG-1:0] ack,
    input  logic             sw_wr,
    input  logic [NFLAG-1:0] sw_bits,
    output logic [NFLAG-1:0] flag_q
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic clr;
        assign clr = ack[i] || (sw_wr && sw_bits[i]);

        always_ff @(posedge clk) begin
            if (rst)            flag_q[i] <= 1'b0;
            else if (hw_set[i]) flag_q[i] <= 1'b1;
            else if (clr)       flag_q[i] <= 1'b0;
        end

        assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && !clr) |=> flag_q[i]);

        assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
            hw_set[i] |=> flag_q[i]);
    end

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  act_e act,
    output logic pin
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst)
            pin_q <= 1'b0;
        else if (hit && act != ACT_OFF)
            pin_q <= pin_after_match(act, pin_q);
    end

    assign pin = (act == ACT_OFF) ? 1'b0 : pin_q;

    assert_set_action_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && act == ACT_SET) |=> pin_q);

    assert_clear_action_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && act == ACT_CLEAR) |=> !pin_q);

    assert_toggle_action_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && act == ACT_TOGGLE) |=> pin_q != $past(pin_q));

    assert_off_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_OFF) |=> $stable(pin_q));

endmodule

// File: rtl/tmr8_regfile.sv
module tmr8_regfile
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_e             wr_sel,
    input  logic [W-1:0]     wr_data,
    input  reg_e             rd_sel,
    input  logic [W-1:0]     cnt_val,
    input  logic [NFLAG-1:0] flags,
    output ctrl_t            ctrl_q,
    output logic [W-1:0]     cmp_q,
    output logic             cnt_wr,
    output logic             flags_wr,
    output logic [W-1:0]     rd_data
);
    assign cnt_wr   = wr_en && wr_sel == REG_COUNT;
    assign flags_wr = wr_en && wr_sel == REG_FLAGS;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            ctrl_q <= '{act: ACT_OFF, mode: MODE_FREE};
        end else if (wr_en) begin
            if (wr_sel == REG_COMPARE) cmp_q  <= wr_data;
            if (wr_sel == REG_CONTROL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_comb begin
        case (rd_sel)
            REG_COUNT:   rd_data = cnt_val;
            REG_COMPARE: rd_data = cmp_q;
            REG_CONTROL: rd_data = W'(ctrl_q);
            default:     rd_data = W'(flags);
        endcase
    end

endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         ovf_ack,
    input  logic         cmp_ack,
    output logic         wave_out,
    output logic         ovf_irq,
    output logic         cmp_irq
);
    ctrl_t            ctrl;
    logic [W-1:0]     cmp_val;
    logic [W-1:0]     cnt;
    logic             cnt_wr;
    logic             flags_wr;
    logic             hit;
    logic             wrapped;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] hw_set;
    logic [NFLAG-1:0] acks;

    tmr8_regfile #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(reg_e'(wr_addr)),
        .wr_data(wr_data), .rd_sel(reg_e'(rd_addr)), .cnt_val(cnt),
        .flags(flag_q), .ctrl_q(ctrl), .cmp_q(cmp_val), .cnt_wr(cnt_wr),
        .flags_wr(flags_wr), .rd_data(rd_data)
    );

    tmr8_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .tick(tick_en), .cnt_wr(cnt_wr),
        .wr_data(wr_data), .cmp_val(cmp_val),
        .wrap_on_cmp(wraps_on_compare(ctrl.mode)),
        .cnt_q(cnt), .hit(hit), .wrapped(wrapped)
    );

    always_comb begin
        hw_set           = '0;
        hw_set[FLAG_OVF] = wrapped;
        hw_set[FLAG_CMP] = hit;
        acks             = '0;
        acks[FLAG_OVF]   = ovf_ack;
        acks[FLAG_CMP]   = cmp_ack;
    end

    tmr8_flags u_flags (
        .clk(clk), .rst(rst), .hw_set(hw_set), .ack(acks),
        .sw_wr(flags_wr), .sw_bits(wr_data[NFLAG-1:0]), .flag_q(flag_q)
    );

    tmr8_wave u_wave (
        .clk(clk), .rst(rst), .hit(hit), .act(ctrl.act), .pin(wave_out)
    );

    assign ovf_irq = flag_q[FLAG_OVF];
    assign cmp_irq = flag_q[FLAG_CMP];

    // R4: overflow flag rises exactly when the counter lands on zero
    assert_ovf_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_irq) |-> cnt == '0);

    // R6: a compare flag rise needs a match on the previous cycle
    assert_cmp_needs_match_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_irq) |-> $past(hit));

endmodule

// File: tb/tb_cmp_timer8.sv
module tb_cmp_timer8;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0, wr_en = 1'b0, ovf_ack = 1'b0, cmp_ack = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       wave_out, ovf_irq, cmp_irq;

    int vectors = 0;
    int miscompares = 0;

    // behavioural model state
    int m_cnt = 0, m_cmp = 0, m_mode = 0, m_act = 0, m_ovf = 0, m_cf = 0, m_pin = 0;

    always #4 clk = ~clk;

    cmp_timer8 dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ovf_ack(ovf_ack), .cmp_ack(cmp_ack), .wave_out(wave_out),
        .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_cmp = 0; m_mode = 0; m_act = 0; m_ovf = 0; m_cf = 0; m_pin = 0;
        end else begin
            bit cw, hit, wrap, clr_o, clr_c;
            cw    = wr_en && wr_addr == 2'd0;
            hit   = tick_en && !cw && m_cnt == m_cmp;
            wrap  = tick_en && !cw && m_cnt == 255;
            clr_o = ovf_ack || (wr_en && wr_addr == 2'd3 && wr_data[0]);
            clr_c = cmp_ack || (wr_en && wr_addr == 2'd3 && wr_data[1]);
            if (hit) begin
                if (m_act == 1) m_pin = 1 - m_pin;
                else if (m_act == 2) m_pin = 0;
                else if (m_act == 3) m_pin = 1;
            end
            if (wrap) m_ovf = 1; else if (clr_o) m_ovf = 0;
            if (hit)  m_cf = 1;  else if (clr_c) m_cf = 0;
            if (cw) m_cnt = wr_data;
            else if (tick_en) m_cnt = (m_mode == 2 && hit) ? 0 : (m_cnt + 1) % 256;
            if (wr_en && wr_addr == 2'd1) m_cmp = wr_data;
            if (wr_en && wr_addr == 2'd2) begin
                m_mode = wr_data[1:0];
                m_act  = wr_data[3:2];
            end
        end
    end

    task automatic check(string tag, int actual, int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
        end
    endtask

    function automatic int model_read(int a);
        case (a)
            0: return m_cnt;
            1: return m_cmp;
            2: return m_act * 4 + m_mode;
            default: return m_cf * 2 + m_ovf;
        endcase
    endfunction

    task automatic compare_all();
        case (int'(rd_addr))
            0: check("R3 R5 R8 R9 counter", rd_data, model_read(0));
            1: check("R2 compare reg", rd_data, model_read(1));
            2: check("R2 control reg", rd_data, model_read(2));
            default: check("R4 R6 R10 flags", rd_data, model_read(3));
        endcase
        check("R7 wave_out", wave_out, (m_act == 0) ? 0 : m_pin);
        check("R11 ovf_irq", ovf_irq, m_ovf);
        check("R11 cmp_irq", cmp_irq, m_cf);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: every register and output is zero straight after reset
        for (int a = 0; a < 4; a++) begin
            rd_addr = a[1:0];
            #1 check("R1 reset value", rd_data, 0);
        end
        check("R1 reset wave", wave_out, 0);
        check("R1 reset irq", ovf_irq | cmp_irq, 0);
        rst = 1'b0;
        for (int ph = 0; ph < 48; ph++) begin
            int mode_sel, act_sel, cmp_sel;
            mode_sel = ph % 4;             // R3 reserved modes, R5 wrap-on-compare
            act_sel  = (ph / 4) % 4;       // R8 same sequence under every action
            cmp_sel  = (ph % 3 == 0) ? 255 : int'($urandom_range(0, 40));
            for (int cyc = 0; cyc < 420; cyc++) begin
                @(negedge clk);
                compare_all();
                rd_addr = 2'(cyc % 4);
                tick_en = ($urandom_range(0, 9) < 7);
                ovf_ack = ($urandom_range(0, 60) == 0);
                cmp_ack = ($urandom_range(0, 30) == 0);
                wr_en   = 1'b0;
                if (cyc == 0) begin
                    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'(act_sel * 4 + mode_sel);
                end else if (cyc == 1) begin
                    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'(cmp_sel);
                end else if ($urandom_range(0, 40) == 0) begin
                    // R9 counter loads near boundaries, R10 flag writes
                    wr_en   = 1'b1;
                    wr_addr = ($urandom_range(0, 1) == 0) ? 2'd0 : 2'd3;
                    case ($urandom_range(0, 2))
                        0: wr_data = 8'($urandom_range(253, 255));
                        1: wr_data = 8'(cmp_sel);
                        default: wr_data = 8'($urandom_range(0, 255));
                    endcase
                end
            end
        end
        @(negedge clk);
        compare_all();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

endmodule